// File: doc/BRIEF.md
# Page Fault Table Walk Sequencer

When address translation misses, this block finds the 16-bit relative disc block number of the missing page. It also handles the case where that number cannot be reached yet. Every paging structure sits at a fixed offset inside the address space it describes. The sequencer therefore builds each structure's virtual address from the faulting address alone, and reads it through a memory port. That port may itself report a fault.

The lookup escalates one step for each failed read. It first reads the page's own table entry. If that read faults, it reads the entry that locates the page of the table holding it. If that read faults too, it asks for page zero of the address space to be found through the disc directory.

Pages below 256 keep their entries in page zero. If that read faults, the block goes straight to the directory step. A one-cycle done pulse reports three things: the level that ended the walk, the block number, and the virtual address of the page the caller should deal with next.

Top module: `tblwalk_seq`

## Requirements
- R1: After reset, `busy`, `memReqValid` and `doneValid` are low and `doneLevel` is 0.
- R2: For a page number below 256, the first read goes to byte offset 0x080 + 2*page of page zero of the same disc and address space. The offset is the low 28 address bits; the page number is bits 27:12.
- R3: For a page number of 256 or more, the first read goes to byte offset 2^28 - 2*(page+1) of the same address space.
- R4: A first read that returns without fault ends the walk with level code 1. The block output carries the returned data, and the resolve address equals the faulting address.
- R5: A faulted first read for a page of 256 or more issues a second read. It goes to byte offset 0x040 + 2*idx of page zero, where idx = (2^17 - 2*(page+1)) >> 12 (range 0..31).
- R6: A second read that returns without fault ends with level code 2. The block output carries the returned data. The resolve address is the 4 KB page that holds the first-read entry.
- R7: A faulted second read, or a faulted first read for a page below 256, ends with level code 3. The block output is 0 and the resolve address is page zero of the space (offset bits 0). No further read is issued.
- R8: At most one read is outstanding. A request stays valid with a stable address until `memReqReady` accepts it.
- R9: A `start` pulse while `busy` is high is ignored, and the walk in progress completes unchanged.
- R10: A response that arrives while no read is outstanding has no effect on state or outputs.
- R11: `doneValid` is high for exactly one cycle. In the next cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk for `faultVa` (taken only when idle) |
| faultVa | input | 60 | Faulting virtual address: disc(8), space(24), page(16), offset(12) |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 60 | Virtual address of the 16-bit entry to read |
| memRspValid | input | 1 | Read response valid |
| memRspFault | input | 1 | The read hit a non-resident page |
| memRspData | input | 16 | Entry value read |
| doneValid | output | 1 | One-cycle result pulse |
| doneLevel | output | 2 | 1 primary entry, 2 secondary entry, 3 directory needed |
| doneBlock | output | 16 | Relative disc block number (0 for level 3) |
| doneResolveVa | output | 60 | Address the caller should resolve next |

## Verification
On every cycle, the assertions check the request handshake: an unaccepted request keeps its address. They also check that the done pulse lasts one cycle and returns the block to idle, and that a start during a walk loads nothing. They further check that an idle block without start stays idle, that the second-table address is never selected for a head-region page, and that a directory result carries a zero block. Only the bench scenarios can show that the arithmetic is right. These scenarios sweep page numbers across the head boundary, the secondary-index boundaries and the top of the table. At each page they try all four fault combinations of page zero and the table pages, together with spurious responses and restarted starts. The scenarios confirm the head-region and top-of-space offsets, the secondary index, the level reached and the resolve address.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;

  // Result level reported with the done pulse
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_PRI  = 2'd1,
    LVL_SEC  = 2'd2,
    LVL_DIR  = 2'd3
  } walk_lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRI_REQ,
    ST_PRI_WAIT,
    ST_SEC_REQ,
    ST_SEC_WAIT,
    ST_DONE
  } walk_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadVa;
    logic      selSec;
    logic      capture;
    walk_lvl_e lvl;
  } walk_strobe_t;

endpackage

// File: rtl/tblwalk_ctrl.sv
module tblwalk_ctrl
  import tblwalk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         isHead,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         memRspFault,
  output logic         memReqValid,
  output logic         busy,
  output logic         doneValid,
  output walk_strobe_t stb
);

  walk_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.lvl   = LVL_NONE;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadVa = 1'b1;
          nextState  = ST_PRI_REQ;
        end
      end
      ST_PRI_REQ: begin
        if (memReqReady) nextState = ST_PRI_WAIT;
      end
      ST_PRI_WAIT: begin
        if (memRspValid) begin
          if (!memRspFault) begin
            stb.capture = 1'b1;
            stb.lvl     = LVL_PRI;
            nextState   = ST_DONE;
          end else if (isHead) begin
            // the head entries live in page zero: the secondary table is gone too
            stb.capture = 1'b1;
            stb.lvl     = LVL_DIR;
            nextState   = ST_DONE;
          end else begin
            nextState = ST_SEC_REQ;
          end
        end
      end
      ST_SEC_REQ: begin
        stb.selSec = 1'b1;
        if (memReqReady) nextState = ST_SEC_WAIT;
      end
      ST_SEC_WAIT: begin
        stb.selSec = 1'b1;
        if (memRspValid) begin
          stb.capture = 1'b1;
          stb.lvl     = memRspFault ? LVL_DIR : LVL_SEC;
          nextState   = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_PRI_REQ) || (state == ST_SEC_REQ);
  assign busy        = (state != ST_IDLE);
  assign doneValid   = (state == ST_DONE);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && !busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !stb.loadVa);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);

  // R5
  sec_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.selSec && memReqValid) |-> !isHead);

endmodule

// File: rtl/tblwalk_dp.sv
module tblwalk_dp
  import tblwalk_pkg::*;
#(
  parameter int DISC_W       = 8,
  parameter int SPACE_W      = 24,
  parameter int PAGE_W       = 16,
  parameter int OFF_W        = 12,
  parameter int HEAD_ENTRIES = 256,
  parameter int SEC_BASE     = 64,
  parameter int ENTRY_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  walk_strobe_t        stb,
  input  logic [DISC_W+SPACE_W+PAGE_W+OFF_W-1:0] faultVa,
  input  logic [ENTRY_W-1:0]  memRspData,
  output logic                isHead,
  output logic [DISC_W+SPACE_W+PAGE_W+OFF_W-1:0] memReqAddr,
  output logic [1:0]          doneLevel,
  output logic [ENTRY_W-1:0]  doneBlock,
  output logic [DISC_W+SPACE_W+PAGE_W+OFF_W-1:0] doneResolveVa
);

  localparam int SOFF_W    = PAGE_W + OFF_W;          // byte offset in a space
  localparam int DS_W      = DISC_W + SPACE_W;
  localparam int VA_W      = DS_W + SOFF_W;
  localparam int SEC_IDX_W = PAGE_W + 1 - OFF_W;      // pages of the full table
  localparam int HEAD_BASE = SEC_BASE + 2 * (2 ** SEC_IDX_W);

  logic [VA_W-1:0]      vaReg;
  logic [DS_W-1:0]      dsPart;
  logic [PAGE_W-1:0]    pageNum;
  logic [SOFF_W-1:0]    headOff, topOff, secOff, priOff;
  logic [PAGE_W:0]      relOff;
  logic [SEC_IDX_W-1:0] secIdx;

  always_ff @(posedge clk) begin
    if (!rstN)           vaReg <= '0;
    else if (stb.loadVa) vaReg <= faultVa;
  end

  assign dsPart  = vaReg[VA_W-1 -: DS_W];
  assign pageNum = vaReg[OFF_W +: PAGE_W];
  assign isHead  = (pageNum < PAGE_W'(HEAD_ENTRIES));

  // head region in page zero, right after the secondary table
  assign headOff = SOFF_W'(HEAD_BASE) + SOFF_W'({pageNum, 1'b0});
  // full table grows down from the top: 2^SOFF_W - 2*(page+1)
  assign topOff  = ~SOFF_W'({pageNum, 1'b1});
  // same entry measured from the table base, split into table pages
  assign relOff  = ~{pageNum, 1'b1};
  assign secIdx  = relOff[PAGE_W -: SEC_IDX_W];
  assign secOff  = SOFF_W'(SEC_BASE) + SOFF_W'({secIdx, 1'b0});
  assign priOff  = isHead ? headOff : topOff;

  assign memReqAddr = {dsPart, (stb.selSec ? secOff : priOff)};

  logic [1:0]         lvlReg;
  logic [ENTRY_W-1:0] blockReg;
  logic [VA_W-1:0]    resolveReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlReg     <= LVL_NONE;
      blockReg   <= '0;
      resolveReg <= '0;
    end else if (stb.capture) begin
      lvlReg <= stb.lvl;
      unique case (stb.lvl)
        LVL_PRI: begin
          blockReg   <= memRspData;
          resolveReg <= vaReg;
        end
        LVL_SEC: begin
          blockReg   <= memRspData;
          resolveReg <= {dsPart, topOff[SOFF_W-1:OFF_W], {OFF_W{1'b0}}};
        end
        default: begin
          blockReg   <= '0;
          resolveReg <= {dsPart, {SOFF_W{1'b0}}};
        end
      endcase
    end
  end

  assign doneLevel     = lvlReg;
  assign doneBlock     = blockReg;
  assign doneResolveVa = resolveReg;

  // R7
  dir_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneLevel == LVL_DIR) |-> (doneBlock == '0));

endmodule

// File: rtl/tblwalk_seq.sv
module tblwalk_seq
  import tblwalk_pkg::*;
#(
  parameter int DISC_W       = 8,
  parameter int SPACE_W      = 24,
  parameter int PAGE_W       = 16,
  parameter int OFF_W        = 12,
  parameter int HEAD_ENTRIES = 256,
  parameter int SEC_BASE     = 64,
  parameter int ENTRY_W      = 16,
  localparam int VA_W        = DISC_W + SPACE_W + PAGE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [VA_W-1:0]    faultVa,
  output logic               busy,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [VA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic               memRspFault,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               doneValid,
  output logic [1:0]         doneLevel,
  output logic [ENTRY_W-1:0] doneBlock,
  output logic [VA_W-1:0]    doneResolveVa
);

  walk_strobe_t stb;
  logic         isHead;

  tblwalk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isHead(isHead),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspFault(memRspFault), .memReqValid(memReqValid),
    .busy(busy), .doneValid(doneValid), .stb(stb)
  );

  tblwalk_dp #(
    .DISC_W(DISC_W), .SPACE_W(SPACE_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .HEAD_ENTRIES(HEAD_ENTRIES), .SEC_BASE(SEC_BASE), .ENTRY_W(ENTRY_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .faultVa(faultVa),
    .memRspData(memRspData), .isHead(isHead), .memReqAddr(memReqAddr),
    .doneLevel(doneLevel), .doneBlock(doneBlock), .doneResolveVa(doneResolveVa)
  );

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid && $stable(memReqAddr));

endmodule

// File: tb/tblwalk_seq_tb.sv
`timescale 1ns/1ps
module tblwalk_seq_tb_top;

  localparam int VA_W = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VA_W-1:0] faultVa = '0;
  logic busy, memReqValid, doneValid;
  logic memReqReady = 1'b0;
  logic [VA_W-1:0] memReqAddr, doneResolveVa;
  logic memRspValid = 1'b0;
  logic memRspFault = 1'b0;
  logic [15:0] memRspData = '0;
  logic [1:0] doneLevel;
  logic [15:0] doneBlock;

  int nChecks = 0;
  int nFail = 0;
  bit zf, tf;   // fault state of page zero / of the table pages at the top

  always #4 clk = ~clk;

  tblwalk_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .faultVa(faultVa), .busy(busy),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspFault(memRspFault), .memRspData(memRspData),
    .doneValid(doneValid), .doneLevel(doneLevel), .doneBlock(doneBlock),
    .doneResolveVa(doneResolveVa)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dataOf(input logic [VA_W-1:0] a);
    return a[16:1] ^ a[32:17] ^ 16'h5A3C;
  endfunction

  function automatic bit faultOf(input logic [VA_W-1:0] a);
    return (a[27:12] == 16'd0) ? zf : tf;
  endfunction

  function automatic logic [27:0] expPriOff(input int page);
    if (page < 256) return 28'(128 + 2 * page);
    return 28'((2 ** 28) - 2 * (page + 1));
  endfunction

  function automatic logic [27:0] expSecOff(input int page);
    return 28'(64 + 2 * ((131072 - 2 * (page + 1)) / 4096));
  endfunction

  task automatic runWalk(input logic [VA_W-1:0] va, input int lat,
                         input bit restart, input bit spur);
    int reqs = 0;
    int pend = -1;
    int cyc = 0;
    bit got = 0;
    logic [VA_W-1:0] a1 = '0, a2 = '0, pendAddr = '0;
    logic [1:0] gl = '0;
    logic [15:0] gb = '0;
    logic [VA_W-1:0] gr = '0;
    int page = int'(va[27:12]);
    logic [31:0] ds = va[59:28];
    int expReqs;
    logic [1:0] expLvl;
    logic [15:0] expBlk;
    logic [VA_W-1:0] expRes;
    logic [VA_W-1:0] priA = {ds, expPriOff(page)};
    logic [VA_W-1:0] secA = {ds, expSecOff(page)};

    if (page < 256) begin
      expReqs = 1;
      if (zf) begin expLvl = 2'd3; expBlk = 16'd0; expRes = {ds, 28'd0}; end
      else begin expLvl = 2'd1; expBlk = dataOf(priA); expRes = va; end
    end else if (!tf) begin
      expReqs = 1; expLvl = 2'd1; expBlk = dataOf(priA); expRes = va;
    end else begin
      expReqs = 2;
      if (zf) begin expLvl = 2'd3; expBlk = 16'd0; expRes = {ds, 28'd0}; end
      else begin expLvl = 2'd2; expBlk = dataOf(secA); expRes = {ds, priA[27:12], 12'd0}; end
    end

    @(negedge clk); faultVa = va; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!got && cyc < 64) begin
      memRspValid = 1'b0; memRspFault = 1'b0; memRspData = '0;
      start = 1'b0;
      if (restart && cyc == 1) begin
        start = 1'b1;
        faultVa = va ^ {8'h3C, 24'h00F00F, 16'hA5A5, 12'h123};
      end
      if (pend == 0) begin
        memRspValid = 1'b1;
        memRspFault = faultOf(pendAddr);
        memRspData  = dataOf(pendAddr);
        pend = -1;
      end else if (pend > 0) pend--;
      memReqReady = ((cyc % 3) != 1);
      if (spur && cyc < 2) begin
        memReqReady = 1'b0;
        if (!memRspValid) begin
          memRspValid = 1'b1; memRspFault = 1'b1; memRspData = 16'hFFFF;
        end
      end
      #1;
      if (memReqValid && memReqReady) begin
        if (reqs == 0) a1 = memReqAddr;
        else if (reqs == 1) a2 = memReqAddr;
        reqs++;
        pend = lat;
        pendAddr = memReqAddr;
      end
      if (doneValid) begin
        got = 1; gl = doneLevel; gb = doneBlock; gr = doneResolveVa;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; memRspValid = 1'b0; memReqReady = 1'b0;

    chk((page < 256) ? "R2 head-region entry address" : "R3 top-of-space entry address",
        64'(a1), 64'(priA));
    if (expReqs == 2) chk("R5 secondary entry address", 64'(a2), 64'(secA));
    chk("R8 R7 number of reads issued", 64'(reqs), 64'(expReqs));
    chk("R9 R10 walk completed", 64'(got), 64'd1);
    chk((expLvl == 2'd1) ? "R4 level" : (expLvl == 2'd2) ? "R6 level" : "R7 level",
        64'(gl), 64'(expLvl));
    chk((expLvl == 2'd3) ? "R7 block" : "R4 R6 block", 64'(gb), 64'(expBlk));
    chk((expLvl == 2'd1) ? "R4 resolve address" :
        (expLvl == 2'd2) ? "R6 resolve address" : "R7 resolve address", 64'(gr), 64'(expRes));
    chk("R11 pulse ends", 64'(doneValid), 64'd0);
    chk("R11 idle after done", 64'(busy), 64'd0);
  endtask

  task automatic idleSpurious();
    logic [1:0] lv = doneLevel;
    logic [15:0] bk = doneBlock;
    logic [VA_W-1:0] rv = doneResolveVa;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      memRspValid = 1'b1; memRspFault = 1'b0; memRspData = 16'h1234;
    end
    @(negedge clk); memRspValid = 1'b0;
    @(negedge clk);
    chk("R10 busy after stray response", 64'(busy), 64'd0);
    chk("R10 no request after stray response", 64'(memReqValid), 64'd0);
    chk("R10 level held", 64'(doneLevel), 64'(lv));
    chk("R10 block held", 64'(doneBlock), 64'(bk));
    chk("R10 resolve held", 64'(doneResolveVa), 64'(rv));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  function automatic logic [VA_W-1:0] mkVa(input int page, input int k);
    logic [7:0] d = 8'(k * 37 + 5);
    logic [23:0] s = 24'(k * 40503 + 11);
    logic [11:0] o = 12'(k * 29);
    return {d, s, 16'(page), o};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int edges[12] = '{0, 1, 255, 256, 257, 4351, 4352, 63487, 63488, 65279, 65280, 65535};
    int k = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy at reset", 64'(busy), 64'd0);
    chk("R1 request at reset", 64'(memReqValid), 64'd0);
    chk("R1 done at reset", 64'(doneValid), 64'd0);
    chk("R1 level at reset", 64'(doneLevel), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (edges[i]) begin
      for (int f = 0; f < 4; f++) begin
        zf = f[0]; tf = f[1];
        runWalk(mkVa(edges[i], k), k % 3, (k % 4) == 1, (k % 5) == 2);
        k++;
      end
    end
    idleSpurious();
    for (int p = 3; p < 65536; p += 251) begin
      for (int f = 0; f < 4; f++) begin
        zf = f[0]; tf = f[1];
        runWalk(mkVa(p, k), (p >> 3) % 3, (p % 3) == 0, (p % 5) == 1);
        k++;
      end
    end
    idleSpurious();
    summary();
  end

endmodule